// File: doc/BRIEF.md
# Configuration Start Power-On Sequencer

This block is the start-up controller of a serial configuration source. After power-on reset it holds an open-drain output-enable line low for a timed window. A pin picks one of two window lengths. When the window ends the line is released, and the block watches for the line to rise. At that rising edge it samples a chip-select input, which in a system is wired to the configuration-done signal of the FPGA being loaded.

A low sample starts configuration. The block then produces a serial clock from the system clock and shifts out bits taken from a valid/ready bit stream. A high sample means the FPGA was not ready at power-up. The block then enters a locked idle state that only another power-on reset can leave. In configuration mode a re-initialisation request restarts the whole handshake. If the FPGA pulls the enable line low to report an error, the serial clock stops and the block waits for the next rising edge.

The bit stream follows these rules. A bit is taken on a clock edge where both `bit_valid` and `bit_ready` are high. `bit_ready` never depends on `bit_valid`. If no bit is offered, the serial clock waits in its current level and `data_out` keeps its value. That is the back-pressure on the producer.

Top module: `cfg_start_seq`

## Requirements
- R1: After `por_n` rises, `oe_drive_low` stays high for exactly CLK_HZ/500 cycles (2 ms) when `por_sel` is 1, and exactly CLK_HZ/10 cycles (100 ms) when `por_sel` is 0. It then goes low.
- R2: While `por_n` is low, `oe_drive_low` is 1. `dclk_out`, `data_out`, `bit_ready`, `config_active` and `idle_locked` are all 0.
- R3: `oe_in` and `ncs_in` each pass through a two-flop synchronizer. On the first synchronized rising edge of `oe_in` after the line is released, a low `ncs_in` makes `config_active` 1.
- R4: If `ncs_in` is high at that rising edge, `idle_locked` becomes 1. While locked, `dclk_out` stays 0, `data_out` is frozen, `bit_ready` is 0 and `oe_drive_low` is 0. `init_conf`, `oe_in`, `ncs_in` and the bit stream have no effect; only `por_n` leaves the state.
- R5: While bits are supplied without a gap, `dclk_out` is low for DCLK_DIV/2 cycles and then high for DCLK_DIV/2 cycles, starting with the low phase.
- R6: `data_out` changes only on the edge where `dclk_out` goes from 1 to 0, or on the first load after entering configuration while `dclk_out` is already 0. It never changes while `dclk_out` is high.
- R7: `bit_ready` is high only in configuration mode, in the first-load wait or the last cycle of a high phase. Without `bit_valid`, `dclk_out` stays at its level and `data_out` holds.
- R8: A one-cycle `init_conf` in configuration mode sets `oe_drive_low` to 1 for exactly INIT_LOW_CYC cycles. `ncs_in` is then sampled again at the next rising edge, exactly as after power-up.
- R9: If the synchronized `oe_in` is low during configuration mode, `config_active` drops the next cycle and `dclk_out` returns to 0 and stops. The next rising edge of `oe_in` samples `ncs_in` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| por_sel | input | 1 | Window length select: 1 = 2 ms, 0 = 100 ms |
| oe_in | input | 1 | Sensed level of the shared output-enable line |
| oe_drive_low | output | 1 | 1 pulls the open-drain enable line low |
| ncs_in | input | 1 | Chip-select input, tied to configuration done |
| init_conf | input | 1 | One-cycle request to restart configuration |
| bit_valid | input | 1 | Producer offers a bit |
| bit_ready | output | 1 | Block accepts the offered bit this cycle |
| bit_in | input | 1 | Offered bit |
| dclk_out | output | 1 | Serial configuration clock |
| data_out | output | 1 | Serial configuration data |
| config_active | output | 1 | High in configuration mode |
| idle_locked | output | 1 | High in the locked idle state |

## Verification
The assertions assume the following about the inputs:
- `por_sel` is constant through each reset window.
- `init_conf` is a single-cycle pulse.
- A producer that raises `bit_valid` keeps it and `bit_in` steady until the transfer.
- INIT_LOW_CYC is at least three, so the synchronizer sees the line low before re-arming.

The stimulus follows these rules. It changes inputs only on falling clock edges. It holds `por_sel` and `ncs_in` fixed from before reset release until the mode is decided. It drops `bit_valid` only in the cycle after a transfer. It pulls the enable line low externally only during configuration mode or the locked state.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_ARM    = 3'd1,
    ST_CONFIG = 3'd2,
    ST_LOCKED = 3'd3,
    ST_REINIT = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } clk_phase_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        hold_q <= meta_q;
      end
    end
    assign q[i] = hold_q;
  end
endmodule

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int CLK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic short_sel,
  output logic done
);
  localparam int LONG_CYC  = CLK_HZ / 10;
  localparam int SHORT_CYC = CLK_HZ / 500;
  localparam int CW        = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = short_sel ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);
  assign done  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + 1'b1;
  end

  // R1: the window never closes before the short length has elapsed
  assert_min_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q >= CW'(SHORT_CYC - 1)));
endmodule

// File: rtl/cfg_dclk_gen.sv
module cfg_dclk_gen
  import cfg_seq_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic valid,
  output logic ready,
  input  logic din,
  output logic dclk,
  output logic dout
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  clk_phase_t    phase_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last  = (cnt_q == CW'(HALF - 1));
  assign ready = en && ((phase_q == PH_LOAD) || ((phase_q == PH_HIGH) && last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      dclk    <= 1'b0;
      dout    <= 1'b0;
    end else if (!en) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      dclk    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          if (valid) begin
            dout    <= din;
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end
        end
        PH_LOW: begin
          if (last) begin
            dclk    <= 1'b1;
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (last) begin
            if (valid) begin
              dout    <= din;
              dclk    <= 1'b0;
              phase_q <= PH_LOW;
              cnt_q   <= '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  // R6: while enabled, a falling clock edge always carries a handshake
  assert_fall_has_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dclk) && $past(en)) |-> $past(valid && ready));
  // R6: the data bit is never altered while the clock is high
  assert_data_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> !dclk);
  // R9: disabling the generator parks the clock low
  assert_park_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !dclk);
endmodule

// File: rtl/cfg_start_seq.sv
module cfg_start_seq
  import cfg_seq_pkg::*;
#(
  parameter int CLK_HZ       = 1_000_000,
  parameter int DCLK_DIV     = 4,
  parameter int INIT_LOW_CYC = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic por_sel,
  input  logic oe_in,
  output logic oe_drive_low,
  input  logic ncs_in,
  input  logic init_conf,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic bit_in,
  output logic dclk_out,
  output logic data_out,
  output logic config_active,
  output logic idle_locked
);
  localparam int IW = $clog2(INIT_LOW_CYC + 1);

  seq_state_t    state_q, state_d;
  logic          oe_s, ncs_s, oe_prev_q, oe_rise;
  logic          por_done;
  logic [IW-1:0] init_cnt_q;
  logic          init_last;

  cfg_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     ({oe_in, ncs_in}),
    .q     ({oe_s, ncs_s})
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) oe_prev_q <= 1'b0;
    else        oe_prev_q <= oe_s;
  end
  assign oe_rise = oe_s && !oe_prev_q;

  cfg_por_timer #(.CLK_HZ(CLK_HZ)) u_por (
    .clk       (clk),
    .rst_n     (por_n),
    .run       (state_q == ST_POR),
    .short_sel (por_sel),
    .done      (por_done)
  );

  assign init_last = (init_cnt_q == IW'(INIT_LOW_CYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   init_cnt_q <= '0;
    else if (state_q != ST_REINIT) init_cnt_q <= '0;
    else if (!init_last)          init_cnt_q <= init_cnt_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:    if (por_done) state_d = ST_ARM;
      ST_ARM: begin
        if (init_conf)    state_d = ST_REINIT;
        else if (oe_rise) state_d = ncs_s ? ST_LOCKED : ST_CONFIG;
      end
      ST_CONFIG: begin
        if (init_conf)    state_d = ST_REINIT;
        else if (!oe_s)   state_d = ST_ARM;
      end
      ST_REINIT: if (init_last) state_d = ST_ARM;
      ST_LOCKED: state_d = ST_LOCKED;
      default:   state_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= ST_POR;
    else        state_q <= state_d;
  end

  assign oe_drive_low  = (state_q == ST_POR) || (state_q == ST_REINIT);
  assign config_active = (state_q == ST_CONFIG);
  assign idle_locked   = (state_q == ST_LOCKED);

  cfg_dclk_gen #(.DIV(DCLK_DIV)) u_dclk (
    .clk   (clk),
    .rst_n (por_n),
    .en    (config_active),
    .valid (bit_valid),
    .ready (bit_ready),
    .din   (bit_in),
    .dclk  (dclk_out),
    .dout  (data_out)
  );

  // R4: the locked state is never left without power-on reset
  assert_locked_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
    idle_locked |=> idle_locked);
  // R4: nothing moves on the serial side while locked
  assert_locked_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
    idle_locked |-> (!dclk_out && !bit_ready && $stable(data_out)));
  // R3: configuration starts only from a rising edge with chip-select low
  assert_cfg_entry_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(config_active) |-> ($past(oe_rise) && !$past(ncs_s)));
  // R9: an external low on the enable line ends configuration mode
  assert_oe_low_stop_R9: assert property (@(posedge clk) disable iff (!por_n)
    (config_active && !oe_s) |=> !config_active);
  // R8: a restart request in configuration drives the line low next cycle
  assert_reinit_drive_R8: assert property (@(posedge clk) disable iff (!por_n)
    (config_active && init_conf) |=> oe_drive_low);
endmodule

// File: tb/sim_cfg_start_seq.sv
module sim_cfg_start_seq;
  localparam int PERIOD   = 10;
  localparam int HZ       = 10000;
  localparam int DIV      = 4;
  localparam int HALF     = DIV / 2;
  localparam int INIT_CYC = 6;
  localparam int SHORT_N  = HZ / 500;
  localparam int LONG_N   = HZ / 10;
  // entry: {por_sel, ncs level, expect config, expect locked}
  localparam logic [3:0] VEC [4] = '{4'b1010, 4'b0010, 4'b1101, 4'b0101};

  logic clk = 1'b0;
  logic por_n = 1'b0, por_sel = 1'b1, ncs_lvl = 1'b0, ext_low = 1'b0;
  logic init_conf = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic oe_drive_low, bit_ready, dclk_out, data_out, config_active, idle_locked;
  logic oe_line;
  int total = 0, bad = 0, hi_changes = 0;
  bit finished = 1'b0;

  always #(PERIOD / 2) clk = ~clk;
  assign oe_line = !oe_drive_low && !ext_low;

  cfg_start_seq #(.CLK_HZ(HZ), .DCLK_DIV(DIV), .INIT_LOW_CYC(INIT_CYC)) u0 (
    .clk(clk), .por_n(por_n), .por_sel(por_sel), .oe_in(oe_line),
    .oe_drive_low(oe_drive_low), .ncs_in(ncs_lvl), .init_conf(init_conf),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_in(bit_in),
    .dclk_out(dclk_out), .data_out(data_out), .config_active(config_active),
    .idle_locked(idle_locked)
  );

  logic prev_data = 1'b0;
  always @(negedge clk) begin
    if (por_n && dclk_out && (data_out !== prev_data)) hi_changes++;
    prev_data <= data_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_cycle(input logic sel, input logic ncs, output int n);
    @(negedge clk);
    por_n = 1'b0; por_sel = sel; ncs_lvl = ncs; ext_low = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    n = 0;
    while (oe_drive_low && n < 200000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_decided();
    for (int g = 0; g < 30 && !config_active && !idle_locked; g++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1; bit_in = b;
    for (int g = 0; g < 1000 && !bit_ready; g++) @(negedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int n;
    logic [4:0] pat;
    logic held;
    // R2: reset state
    repeat (3) @(negedge clk);
    chk(oe_drive_low && !dclk_out && !data_out && !bit_ready && !config_active && !idle_locked,
        "R2 reset state", {oe_drive_low, dclk_out, data_out, bit_ready, config_active, idle_locked}, 6'b100000);

    // table walk: window length and decision
    for (int i = 0; i < 4; i++) begin
      power_cycle(VEC[i][3], VEC[i][2], n);
      chk(n == (VEC[i][3] ? SHORT_N : LONG_N), "R1 window length", n, VEC[i][3] ? SHORT_N : LONG_N);
      wait_decided();
      chk(config_active == VEC[i][1], "R3 config after low sample", config_active, VEC[i][1]);
      chk(idle_locked == VEC[i][0], "R4 locked after high sample", idle_locked, VEC[i][0]);
    end

    // stream in configuration mode
    power_cycle(1'b1, 1'b0, n);
    wait_decided();
    chk(bit_ready && !dclk_out, "R7 ready in first load", {bit_ready, dclk_out}, 2'b10);
    pat = 5'b01101;
    hi_changes = 0;
    for (int k = 0; k < 5; k++) begin
      send_bit(pat[k]);
      chk(data_out == pat[k] && !dclk_out, "R6 bit presented on low clock", data_out, pat[k]);
    end
    n = 0;
    while (!dclk_out && n < 100) begin n++; @(negedge clk); end
    chk(n == HALF, "R5 low phase length", n, HALF);
    bit_valid = 1'b1; bit_in = 1'b0;
    n = 0;
    while (dclk_out && n < 100) begin n++; @(negedge clk); end
    bit_valid = 1'b0;
    chk(n == HALF, "R5 high phase length", n, HALF);
    chk(data_out == 1'b0, "R6 bit at falling edge", data_out, 0);
    // back-pressure stall
    repeat (HALF + 6) @(negedge clk);
    held = data_out;
    chk(dclk_out && bit_ready, "R7 stall high with ready", {dclk_out, bit_ready}, 2'b11);
    repeat (5) @(negedge clk);
    chk(dclk_out && data_out == held, "R7 no change without valid", data_out, held);
    send_bit(1'b1);
    chk(data_out && !dclk_out, "R7 transfer after stall", data_out, 1);
    chk(hi_changes == 0, "R6 no change while clock high", hi_changes, 0);

    // restart request in configuration
    init_conf = 1'b1; @(negedge clk); init_conf = 1'b0;
    n = 0;
    while (oe_drive_low && n < 100) begin n++; @(negedge clk); end
    chk(n == INIT_CYC, "R8 restart low time", n, INIT_CYC);
    wait_decided();
    chk(config_active, "R8 reconfig after restart", config_active, 1);

    // external low during configuration
    send_bit(1'b0);
    ext_low = 1'b1;
    repeat (6) @(negedge clk);
    chk(!config_active && !dclk_out && !bit_ready, "R9 stop on external low",
        {config_active, dclk_out, bit_ready}, 0);
    ext_low = 1'b0;
    wait_decided();
    chk(config_active, "R9 resample after release", config_active, 1);

    // restart with chip-select high leads to lock
    ncs_lvl = 1'b1;
    init_conf = 1'b1; @(negedge clk); init_conf = 1'b0;
    repeat (INIT_CYC) @(negedge clk);
    wait_decided();
    chk(idle_locked && !config_active, "R8 resample locks", idle_locked, 1);

    // locked immunity
    held = data_out;
    n = 0;
    for (int c = 0; c < 60; c++) begin
      init_conf = (c % 10 == 3);
      ext_low   = (c >= 20 && c < 30);
      ncs_lvl   = (c < 40);
      bit_valid = 1'b1; bit_in = ~held;
      @(negedge clk);
      if (dclk_out || bit_ready || !idle_locked || data_out != held) n++;
    end
    init_conf = 1'b0; ext_low = 1'b0; bit_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(n == 0 && idle_locked, "R4 locked ignores inputs", n, 0);
    chk(!oe_drive_low && !dclk_out, "R4 locked line released", {oe_drive_low, dclk_out}, 0);
    power_cycle(1'b1, 1'b0, n);
    wait_decided();
    chk(config_active && !idle_locked, "R4 power cycle clears lock", config_active, 1);

    finish_run();
  end
endmodule